// File: doc/BRIEF.md
# Page write load controller

This block is the write-side control of a byte-wide non-volatile memory with a page buffer, written as a synchronous model. The chip-enable, write-enable and output-enable strobes arrive without regard to the clock. They pass through a synchroniser, and a byte write is the span during which both enables are low and output-enable is high. The address is taken when that span opens and the data when it closes. Each accepted byte goes into a 32-entry page buffer, and each one re-arms a load window counter.

When the load window runs out with no new accepted byte, the block enters a self-timed programming phase. Busy stays low for that whole phase. At the end, the buffered bytes are copied into a small internal array, which can be read through a plain combinational read port. The window length, the programming length and the power-up hold-off are parameters given in clock cycles.

The pins `addr` and `din` must stay stable for at least three clock cycles after the strobe edge that captures them, because the synchroniser and the edge register delay the capture.

Top module: `pgwr_ctrl`

## Requirements
- R1: A byte write is recognised only while `ce_n`=0, `we_n`=0 and `oe_n`=1 hold together. A strobe pair issued with `oe_n`=0 loads nothing and starts no programming.
- R2: The address is captured when the later of `ce_n`/`we_n` falls, which opens the write condition. The data is captured when the earlier of them rises, which closes it. Later address changes and earlier data values have no effect.
- R3: A byte address splits into an offset `addr[4:0]` (the buffer entry) and a page `addr[12:5]`. The array holds four pages selected by `addr[6:5]`. `rd_data` shows array byte `rd_addr` = {`addr[6:5]`,`addr[4:0]`} in the same cycle.
- R4: A byte whose page differs from the first byte of the current load is discarded and does not re-arm the window. It sets `page_err`, which stays 1 until reset.
- R5: Each accepted byte re-arms a window of `LOAD_CYC` cycles. Programming starts only when the window expires with no further accepted byte.
- R6: Programming holds `busy_n` at 0 for `PROG_CYC` cycles and then releases it. The array keeps its old contents until the end of the phase.
- R7: Write strobes during programming are ignored and do not lengthen the phase.
- R8: Only the bytes loaded are committed. The other bytes of the page keep their old values, and the buffer is empty again after the commit.
- R9: For `PWRUP_CYC` cycles after reset is released, write strobes are ignored.
- R10: Writing the same offset twice within one load keeps the later byte.
- R11: After reset, `busy_n`=1, `page_err`=0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable strobe, asynchronous, active low |
| we_n | input | 1 | Write enable strobe, asynchronous, active low |
| oe_n | input | 1 | Output enable strobe, asynchronous, active low |
| addr | input | 13 | Byte address (page and offset) |
| din | input | 8 | Write data |
| rd_addr | input | 7 | Array read address |
| rd_data | output | 8 | Array read data |
| busy_n | output | 1 | Low while programming |
| page_err | output | 1 | Sticky flag for a discarded byte from a foreign page |

## Verification
The hardest state to reach is a strobe that lands inside the programming phase. It is also hard to tell a re-armed window apart from an expired one. The stimulus reaches the first case by watching `busy_n` fall and then issuing a complete strobe pair well inside the phase. It then measures that the low time of `busy_n` is unchanged and that the targeted byte still reads its old value. For re-arming, bytes are spaced closer than the window but with a total span longer than it, and `busy_n` is checked to stay high between them.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pgwr_strobe_sync.sv
module pgwr_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_start,
  output logic wr_end
);
  localparam int NSTRB = 3;

  logic [NSTRB-1:0] raw_n;
  logic [NSTRB-1:0] sync_n;
  logic             wr_act;
  logic             wr_act_q;

  assign raw_n = {oe_n, we_n, ce_n};

  for (genvar i = 0; i < NSTRB; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-2:0], raw_n[i]};
    end
    assign sync_n[i] = chain[SYNC_STAGES-1];
  end

  // write condition: both enables low, output enable high
  assign wr_act = ~sync_n[0] & ~sync_n[1] & sync_n[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_act_q <= 1'b0;
    else        wr_act_q <= wr_act;
  end

  assign wr_start = wr_act & ~wr_act_q;
  assign wr_end   = ~wr_act & wr_act_q;
endmodule

// File: rtl/pgwr_tmr.sv
module pgwr_tmr #(
  parameter int LIMIT       = 16,
  parameter bit START_ARMED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expire,
  output logic running
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= START_ARMED ? CW'(LIMIT) : '0;
    else if (arm)        cnt <= CW'(LIMIT);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign expire  = (cnt == CW'(1)) && !arm;
  assign running = (cnt != '0);

  AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT)); // R5
endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [OFS_W-1:0]              wr_ofs,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          clr,
  output logic [(1<<OFS_W)*DATA_W-1:0]  buf_data,
  output logic [(1<<OFS_W)-1:0]         buf_vld
);
  localparam int PAGE_SZ = 1 << OFS_W;

  for (genvar i = 0; i < PAGE_SZ; i++) begin : g_ent
    logic [DATA_W-1:0] ent_d;
    logic              ent_v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_d <= '0;
        ent_v <= 1'b0;
      end else if (clr) begin
        ent_v <= 1'b0;
      end else if (wr_en && (wr_ofs == OFS_W'(i))) begin
        ent_d <= wr_data;
        ent_v <= 1'b1;
      end
    end
    assign buf_data[i*DATA_W +: DATA_W] = ent_d;
    assign buf_vld[i]                   = ent_v;
  end
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int DATA_W   = 8,
  parameter int OFS_W    = 5,
  parameter int ARR_PG_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [ARR_PG_W-1:0]           commit_pg,
  input  logic [(1<<OFS_W)*DATA_W-1:0]  buf_data,
  input  logic [(1<<OFS_W)-1:0]         buf_vld,
  input  logic [ARR_PG_W+OFS_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]             rd_data
);
  localparam int PAGE_SZ = 1 << OFS_W;
  localparam int ARR_SZ  = 1 << (ARR_PG_W + OFS_W);

  logic [DATA_W-1:0] mem [ARR_SZ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ARR_SZ; k++) mem[k] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_SZ; i++) begin
        if (buf_vld[i]) mem[{commit_pg, OFS_W'(i)}] <= buf_data[i*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int OFS_W     = 5,
  parameter int ARR_PG_W  = 2,
  parameter int LOAD_CYC  = 5000,
  parameter int PROG_CYC  = 250000,
  parameter int PWRUP_CYC = 500000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_n,
  input  logic                      we_n,
  input  logic                      oe_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         din,
  input  logic [ARR_PG_W+OFS_W-1:0] rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      busy_n,
  output logic                      page_err
);
  localparam int PAGE_W  = ADDR_W - OFS_W;
  localparam int PAGE_SZ = 1 << OFS_W;

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] ofs_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  function automatic logic [ARR_PG_W-1:0] arr_pg(input logic [PAGE_W-1:0] p);
    return p[ARR_PG_W-1:0];
  endfunction

  pg_state_e           state;
  logic [ADDR_W-1:0]   cap_addr;
  logic                cap_vld;
  logic [PAGE_W-1:0]   cur_page;
  logic                err_q;

  logic wr_start, wr_end;
  logic end_ok, same_pg, buf_wr, pg_miss;
  logic load_exp, load_run, prog_exp, prog_run, pwr_exp, pwr_run, pwr_ok;
  logic prog_arm, commit;
  logic [PAGE_SZ*DATA_W-1:0] buf_data;
  logic [PAGE_SZ-1:0]        buf_vld;

  pgwr_strobe_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_start(wr_start), .wr_end(wr_end)
  );

  pgwr_tmr #(.LIMIT(PWRUP_CYC), .START_ARMED(1'b1)) u_pwr_tmr (
    .clk(clk), .rst_n(rst_n), .arm(1'b0), .expire(pwr_exp), .running(pwr_run)
  );

  pgwr_tmr #(.LIMIT(LOAD_CYC), .START_ARMED(1'b0)) u_load_tmr (
    .clk(clk), .rst_n(rst_n), .arm(buf_wr), .expire(load_exp), .running(load_run)
  );

  pgwr_tmr #(.LIMIT(PROG_CYC), .START_ARMED(1'b0)) u_prog_tmr (
    .clk(clk), .rst_n(rst_n), .arm(prog_arm), .expire(prog_exp), .running(prog_run)
  );

  assign pwr_ok = ~pwr_run;

  always_comb begin
    end_ok   = wr_end && cap_vld && (state != ST_PROG);
    same_pg  = (page_of(cap_addr) == cur_page);
    buf_wr   = end_ok && ((state == ST_IDLE) || same_pg);
    pg_miss  = end_ok && (state == ST_LOAD) && !same_pg;
    prog_arm = (state == ST_LOAD) && load_exp;
    commit   = (state == ST_PROG) && prog_exp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cap_addr <= '0;
      cap_vld  <= 1'b0;
      cur_page <= '0;
      err_q    <= 1'b0;
    end else begin
      if (wr_start) begin
        cap_vld <= pwr_ok && (state != ST_PROG);
        if (pwr_ok && (state != ST_PROG)) cap_addr <= addr;
      end else if (wr_end) begin
        cap_vld <= 1'b0;
      end
      if (pg_miss) err_q <= 1'b1;
      case (state)
        ST_IDLE: if (buf_wr) begin
          cur_page <= page_of(cap_addr);
          state    <= ST_LOAD;
        end
        ST_LOAD: if (load_exp) state <= ST_PROG;
        ST_PROG: if (prog_exp) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  pgwr_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_wr), .wr_ofs(ofs_of(cap_addr)),
    .wr_data(din), .clr(commit), .buf_data(buf_data), .buf_vld(buf_vld)
  );

  pgwr_array #(.DATA_W(DATA_W), .OFS_W(OFS_W), .ARR_PG_W(ARR_PG_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_pg(arr_pg(cur_page)),
    .buf_data(buf_data), .buf_vld(buf_vld), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign busy_n   = (state != ST_PROG);
  assign page_err = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err); // R4
  AST_BUSY_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(load_exp)); // R5
  AST_LOAD_WINDOW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |-> load_run); // R5
  AST_PROG_TIMER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG) |-> prog_run); // R6
  AST_PROG_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && !prog_exp) |=> $stable(buf_vld)); // R7
  AST_IDLE_BUF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (buf_vld == '0)); // R8
  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_ok || pwr_exp) |-> (busy_n && state == ST_IDLE)); // R9
endmodule

// File: tb/pgwr_ctrl_tb_top.sv
module pgwr_ctrl_tb_top;
  localparam int LOAD_T  = 40;
  localparam int PROG_T  = 60;
  localparam int PWRUP_T = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic [6:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy_n, page_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] model [128];

  always #10 clk = ~clk;

  pgwr_ctrl #(.LOAD_CYC(LOAD_T), .PROG_CYC(PROG_T), .PWRUP_CYC(PWRUP_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy_n(busy_n), .page_err(page_err)
  );

  // write entries: address, data (all page 1)
  localparam logic [20:0] VEC [6] = '{
    {13'h0020, 8'hA5}, {13'h003F, 8'h3C}, {13'h0027, 8'h11},
    {13'h0030, 8'hF0}, {13'h0023, 8'h7E}, {13'h002F, 8'hC2}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slot(input logic [12:0] a);
    return int'(a) % 128;
  endfunction

  task automatic strobe(input logic [12:0] a, input logic [7:0] d, input logic oe);
    addr = a; din = d; oe_n = oe;
    @(posedge clk);
    ce_n = 1'b0; tick(2);
    we_n = 1'b0; tick(5);
    we_n = 1'b1; tick(5);
    ce_n = 1'b1; oe_n = 1'b1; tick(2);
  endtask

  task automatic rd(input logic [12:0] a, output int v);
    rd_addr = a[6:0];
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic wait_low(output int n);
    n = 0;
    @(negedge clk);
    while (busy_n && n < 400) begin n++; @(negedge clk); end
  endtask

  task automatic wait_high(output int n);
    n = 0;
    while (!busy_n && n < 400) begin n++; @(negedge clk); end
  endtask

  task automatic quiet(input int cyc, output int lows);
    lows = 0;
    repeat (cyc) begin @(negedge clk); if (!busy_n) lows++; end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int v, n, lo;
    for (int k = 0; k < 128; k++) model[k] = 8'h00;
    tick(3);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 busy_n", int'(busy_n), 1);
    check("R11 page_err", int'(page_err), 0);
    rd(13'h0000, v); check("R11 array zero", v, 0);

    // R9 power-up hold-off
    tick(5);
    strobe(13'h0001, 8'h5A, 1'b0 ^ 1'b1);
    quiet(PWRUP_T + LOAD_T, lo);
    check("R9 no programming during hold-off", lo, 0);
    rd(13'h0001, v); check("R9 byte ignored", v, 0);

    // R3/R5/R6/R8 table of page writes
    for (int i = 0; i < 6; i++) begin
      strobe(VEC[i][20:8], VEC[i][7:0], 1'b1);
      model[slot(VEC[i][20:8])] = VEC[i][7:0];
    end
    wait_low(n);
    check("R5 window length", int'(n >= 25 && n <= 45), 1);
    rd(13'h0020, v); check("R6 old data while busy", v, 0);
    wait_high(lo);
    check("R6 programming length", int'(lo >= PROG_T - 5 && lo <= PROG_T + 5), 1);
    for (int i = 0; i < 6; i++) begin
      rd(VEC[i][20:8], v);
      check("R3 committed byte", v, int'(model[slot(VEC[i][20:8])]));
    end
    rd(13'h0021, v); check("R8 unloaded byte kept", v, 0);

    // R5 re-arm: bytes closer than the window, total span longer
    strobe(13'h0040, 8'h01, 1'b1); tick(10);
    check("R5 re-arm 1", int'(busy_n), 1);
    strobe(13'h0041, 8'h02, 1'b1); tick(10);
    check("R5 re-arm 2", int'(busy_n), 1);
    strobe(13'h0042, 8'h03, 1'b1);
    model[slot(13'h0040)] = 8'h01; model[slot(13'h0041)] = 8'h02; model[slot(13'h0042)] = 8'h03;
    wait_low(n);
    check("R5 window after last byte", int'(n >= 25 && n <= 45), 1);
    // R7 strobe inside programming
    tick(5);
    strobe(13'h0045, 8'h99, 1'b1);
    @(negedge clk);
    wait_high(lo);
    check("R7 phase not lengthened", int'(lo + 21 >= PROG_T - 5 && lo + 21 <= PROG_T + 5), 1);
    rd(13'h0045, v); check("R7 strobe ignored", v, 0);
    rd(13'h0041, v); check("R5 re-armed bytes kept", v, 2);
    quiet(LOAD_T + 10, lo);
    check("R7 no later programming", lo, 0);

    // R4 foreign page byte
    strobe(13'h0048, 8'h81, 1'b1);
    strobe(13'h0068, 8'h82, 1'b1);
    check("R4 page_err set", int'(page_err), 1);
    wait_low(n); wait_high(lo);
    rd(13'h0048, v); check("R4 own page byte", v, 'h81);
    rd(13'h0068, v); check("R4 foreign byte dropped", v, 0);
    check("R4 page_err sticky", int'(page_err), 1);

    // R1 strobe with output enable low
    strobe(13'h0050, 8'h77, 1'b0);
    quiet(LOAD_T + 20, lo);
    check("R1 no programming", lo, 0);
    rd(13'h0050, v); check("R1 byte not written", v, 0);

    // R2 capture edges
    addr = 13'h0062; din = 8'h00; oe_n = 1'b1;
    @(posedge clk);
    we_n = 1'b0; tick(2);
    ce_n = 1'b0; tick(5);
    addr = 13'h0069; din = 8'hD1; tick(2);
    din = 8'hD2; tick(5);
    ce_n = 1'b1; tick(5);
    we_n = 1'b1; tick(2);
    wait_low(n); wait_high(lo);
    rd(13'h0062, v); check("R2 first address, last data", v, 'hD2);
    rd(13'h0069, v); check("R2 late address unused", v, 0);

    // R10 same offset twice
    strobe(13'h0064, 8'h12, 1'b1);
    strobe(13'h0064, 8'h34, 1'b1);
    wait_low(n); wait_high(lo);
    rd(13'h0064, v); check("R10 later byte kept", v, 'h34);

    // R11 reset again
    rst_n = 1'b0; tick(3);
    @(negedge clk); rst_n = 1'b1;
    check("R11 page_err cleared", int'(page_err), 0);
    rd(13'h0020, v); check("R11 array cleared", v, 0);

    finish_run();
  end
endmodule